// File: doc/BRIEF.md
# Watchdog Timer with Interrupt and Reset Modes

This block supervises software by counting prescaled clock ticks. If the count is not cleared in time, it raises a timeout. An eight-bit control and status register holds the mode and the period. Two enable bits choose what a timeout does. An interrupt enable makes the timeout set a sticky flag and request an interrupt. A reset enable makes the timeout request a system reset for one cycle. With both enables set, a timeout does both. With neither set, the counter stops.

The CPU drives three inputs. The global interrupt enable gates the interrupt request. An acknowledge strobe, sent when the CPU runs the interrupt vector, clears the flag. A kick pulse restarts the count from zero. Software can also clear the flag by writing 1 to its register bit. The change-enable bit is stored and read back but has no timing effect. The timeout period is 2^(BASE_EXP+N) ticks, where N is the four-bit period code; codes above MAX_CODE act as MAX_CODE.

Top module: `wdog_top`

## Requirements
- R1: After reset the register reads 0x00, except bit 3 (reset enable), which reads the WDE_RST parameter. `irq` and `resetReq` are low after reset.
- R2: Register layout: bit 7 is the timeout flag, bit 6 the interrupt enable, bit 5 period code bit 3, bit 4 the change-enable bit, bit 3 the reset enable, and bits 2:0 period code bits 2:0. A write stores bits 6..0, and they read back unchanged. Writing 1 to bit 7 never sets the flag.
- R3: With the counter running from zero, a timeout occurs on the 2^(BASE_EXP+N)-th tick, where N is the period code. Any code above MAX_CODE gives the same period as MAX_CODE.
- R4: With the interrupt enable at 1 and the reset enable at 0, a timeout sets the flag and leaves `resetReq` low.
- R5: With the reset enable at 1 and the interrupt enable at 0, a timeout drives `resetReq` high for exactly one cycle, and the flag stays 0.
- R6: With both enables at 1, a single timeout both sets the flag and pulses `resetReq`.
- R7: With both enables at 0, the counter neither counts nor clears. It keeps its value until counting resumes, and no timeout occurs.
- R8: `irq` is high only while the flag, the interrupt enable and `globalIntEn` are all 1.
- R9: The flag is cleared by an `intAck` pulse, or by a write with bit 7 at 1. A write with bit 7 at 0 leaves it unchanged. A timeout in the same cycle as a clear wins, so the flag stays set.
- R10: A `kick` pulse returns the counter to zero. The next timeout then needs a full period of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Prescaled tick; the counter advances on clock edges where this is high |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| globalIntEn | input | 1 | CPU global interrupt enable |
| intAck | input | 1 | Interrupt vector acknowledge, clears the flag |
| kick | input | 1 | Watchdog restart pulse, clears the counter |
| irq | output | 1 | Interrupt request |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `kick`, `intAck` and `regWrEn` are single-cycle strobes. They also assume that BASE_EXP is at least 1, so two timeouts can never fall on consecutive ticks. The stimulus drives every strobe for exactly one cycle. It holds `tickEn` low while it writes the register or kicks the counter. The bench shortens BASE_EXP so that even the clamped period code finishes within a few thousand ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int FLAG_BIT  = 7;
  localparam int IE_BIT    = 6;
  localparam int SEL_HI    = 5;
  localparam int CHGEN_BIT = 4;
  localparam int RE_BIT    = 3;

  typedef struct packed {
    logic       run;
    logic       clear;
    logic [3:0] sel;
  } wdogCmd_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  wdogCmd_t cmd,
  input  logic     tickEn,
  output logic     timeout
);
  localparam int CNT_W = BASE_EXP + MAX_CODE;
  localparam logic [3:0] MAX_SEL = 4'(MAX_CODE);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;
  logic [CNT_W:0]   spanVal;
  logic [3:0]       selEff;

  // Clamp the period code, then derive the final count value of the period.
  always_comb begin
    selEff  = (cmd.sel > MAX_SEL) ? MAX_SEL : cmd.sel;
    spanVal = (CNT_W+1)'(1) << (BASE_EXP + int'(selEff));
    lastVal = CNT_W'(spanVal - (CNT_W+1)'(1));
  end

  assign timeout = cmd.run & tickEn & ~cmd.clear & (count >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (cmd.clear)       count <= '0;
    else if (cmd.run && tickEn) count <= timeout ? '0 : count + 1'b1;
  end

  AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (count == '0)); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.clear) |=> $stable(count)); // R7
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter bit WDE_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       globalIntEn,
  input  logic       intAck,
  input  logic       kick,
  input  logic       timeout,
  output wdogCmd_t   cmd,
  output logic       irq,
  output logic       resetReq
);
  logic       flag;
  logic       intEn;
  logic       rstEn;
  logic       chgEn;
  logic [3:0] sel;
  logic       swClear;

  assign swClear = regWrEn & regWrData[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn <= 1'b0;
      rstEn <= WDE_RST;
      chgEn <= 1'b0;
      sel   <= '0;
    end else if (regWrEn) begin
      intEn <= regWrData[IE_BIT];
      rstEn <= regWrData[RE_BIT];
      chgEn <= regWrData[CHGEN_BIT];
      sel   <= {regWrData[SEL_HI], regWrData[2:0]};
    end
  end

  // A timeout beats a clear that arrives in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flag <= 1'b0;
    else if (timeout && intEn)  flag <= 1'b1;
    else if (intAck || swClear) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= timeout & rstEn;
  end

  always_comb begin
    cmd.run   = intEn | rstEn;
    cmd.clear = kick;
    cmd.sel   = sel;
  end

  assign irq       = flag & intEn & globalIntEn;
  assign regRdData = {flag, intEn, sel[3], chgEn, rstEn, sel[2:0]};

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq); // R5
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(intEn)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !timeout) |=> !flag); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !globalIntEn |-> !irq); // R8
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!intEn && !rstEn) |=> !resetReq); // R7
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9,
  parameter bit WDE_RST  = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       globalIntEn,
  input  logic       intAck,
  input  logic       kick,
  output logic       irq,
  output logic       resetReq
);
  wdogCmd_t cmd;
  logic     timeout;

  wdog_ctrl #(.WDE_RST(WDE_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .globalIntEn(globalIntEn), .intAck(intAck),
    .kick(kick), .timeout(timeout), .cmd(cmd), .irq(irq), .resetReq(resetReq)
  );

  wdog_count #(.BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cmd), .tickEn(tickEn), .timeout(timeout)
  );
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int BEXP = 4;
  localparam int NVEC = 5;
  localparam logic [15:0] VECS [NVEC] = '{
    16'h5555, 16'hAA2A, 16'h7F7F, 16'h8000, 16'h0000
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, regWrEn = 1'b0, globalIntEn = 1'b0, intAck = 1'b0, kick = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq, resetReq;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wdog_top #(.BASE_EXP(BEXP), .MAX_CODE(9), .WDE_RST(1'b0)) i_wdog_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .globalIntEn(globalIntEn),
    .intAck(intAck), .kick(kick), .irq(irq), .resetReq(resetReq)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; cyc(); regWrEn = 1'b0;
  endtask

  task automatic doKick();
    kick = 1'b1; cyc(); kick = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1; repeat (n) cyc(); tickEn = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk("R1 reg", regRdData, 8'h00);
    chk("R1 outs", {6'b0, irq, resetReq}, 8'h00);
    rstN = 1'b1;
    cyc();

    // R2 layout vectors: write data / expected read
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][15:8]);
      chk("R2 readback", regRdData, VECS[i][7:0]);
    end

    // R4 interrupt-only mode, R8 gating, R9 acknowledge
    wr(8'h40); doKick();
    ticks(15);
    chk("R4 before period", regRdData[7], 1'b0);
    tickEn = 1'b1; cyc(); tickEn = 1'b0;
    chk("R4 flag", regRdData[7], 1'b1);
    chk("R4 no reset", resetReq, 1'b0);
    chk("R8 gie off", irq, 1'b0);
    globalIntEn = 1'b1; #1;
    chk("R8 irq", irq, 1'b1);
    intAck = 1'b1; cyc(); intAck = 1'b0;
    chk("R9 ack clears", regRdData[7], 1'b0);
    chk("R8 irq drop", irq, 1'b0);

    // R9 software clear
    ticks(16);
    chk("R9 flag again", regRdData[7], 1'b1);
    wr(8'h40);
    chk("R9 write0 keeps", regRdData[7], 1'b1);
    wr(8'hC0);
    chk("R9 write1 clears", regRdData[7], 1'b0);

    // R3 period code 1 -> 2^(BEXP+1)
    wr(8'hC1); doKick();
    ticks(31);
    chk("R3 code1 early", regRdData[7], 1'b0);
    ticks(1);
    chk("R3 code1 period", regRdData[7], 1'b1);

    // R3 clamp: codes 15 and 10 behave as 9
    wr(8'hE7); doKick();
    ticks(8191);
    chk("R3 code15 early", regRdData[7], 1'b0);
    ticks(1);
    chk("R3 code15 clamp", regRdData[7], 1'b1);
    wr(8'hE2); doKick();
    ticks(8191);
    chk("R3 code10 early", regRdData[7], 1'b0);
    ticks(1);
    chk("R3 code10 clamp", regRdData[7], 1'b1);

    // R5 reset-only mode
    globalIntEn = 1'b0;
    wr(8'h88); doKick();
    ticks(15);
    chk("R5 early", resetReq, 1'b0);
    tickEn = 1'b1; cyc(); tickEn = 1'b0;
    chk("R5 pulse", resetReq, 1'b1);
    chk("R5 no flag", regRdData[7], 1'b0);
    cyc();
    chk("R5 one cycle", resetReq, 1'b0);

    // R6 both enables
    wr(8'hC8); doKick();
    ticks(15);
    tickEn = 1'b1; cyc(); tickEn = 1'b0;
    chk("R6 reset", resetReq, 1'b1);
    chk("R6 flag", regRdData[7], 1'b1);
    cyc();

    // R7 stopped counter keeps its value
    wr(8'hC0); doKick();
    ticks(10);
    wr(8'h00);
    ticks(50);
    chk("R7 no event", {regRdData[7], resetReq}, 2'b00);
    wr(8'h40);
    ticks(5);
    chk("R7 held early", regRdData[7], 1'b0);
    ticks(1);
    chk("R7 held count", regRdData[7], 1'b1);

    // R10 kick restarts the period
    wr(8'hC0); doKick();
    ticks(10);
    doKick();
    ticks(15);
    chk("R10 after kick", regRdData[7], 1'b0);
    ticks(1);
    chk("R10 full period", regRdData[7], 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule